// File: doc/BRIEF.md
# Flash Configuration Register Reset Loader

This block keeps the configuration state of a serial flash memory. It holds a 16-bit persistent configuration word and two 8-bit volatile configuration registers. It also holds the flag that selects 4-byte addressing, a 2-bit address bank register and the write-enable latch. Whenever the state is reset, the volatile registers are rebuilt one field at a time from the persistent word.

Traffic reaches the block as bytes that have already been deserialized. Each byte carries a valid strobe and arrives inside a select window. The first byte after select goes high, and every byte that follows a finished command, is an opcode. The bytes that follow a configuration-write opcode are its data. A hardware reset loads the persistent word from a parameter and derives the volatile state from that value. A software reset needs two commands: the arming opcode, and then the reset opcode as the very next opcode. It derives the volatile state from the persistent word as it stands at that moment, and it leaves the persistent word unchanged.

Top module: `flash_cfg_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the persistent word loads `NV_DEFAULT` (default 0x8FFF). The volatile state is derived from that value as R2 to R4 describe, `wr_latch` clears and `await_op` goes to 1. With the default value the outputs are `vol_cfg`=0x83, `xvol_cfg`=0xDF, `wide_addr`=0 and `addr_bank`=0.
- R2: On a reset, `vol_cfg` bits [1:0] are set to 1. Bit 2 is 0. Bit 3 is 1 exactly when persistent bits [11:9] differ from 3'b111. Bits [7:4] copy persistent bits [15:12].
- R3: On a reset, `xvol_cfg` bits [2:0] are loaded with `DRIVE_STRENGTH` (default 7), bits 3 and 4 are set and bit 5 is 0. Bit 6 copies persistent bit 2 and bit 7 copies persistent bit 3.
- R4: On a reset, `wide_addr` becomes the inverse of persistent bit 0. `addr_bank` becomes 3 when persistent bit 1 is 0, and 0 otherwise.
- R5: Opcode 0x66 arms a software reset and any other opcode disarms it. Opcode 0x99 performs the R2 to R4 reload from the current persistent word and clears `wr_latch`, but only while armed. Otherwise it has no effect. The persistent word is kept across a software reset.
- R6: Opcode 0x06 sets `wr_latch` and opcode 0x04 clears it. Configuration writes leave it unchanged.
- R7: With `wr_latch` at 1, four opcodes write the registers. 0xB1 is followed by two data bytes, low byte first, into the persistent word. 0x81 takes one byte into `vol_cfg`. 0x61 takes one byte into `xvol_cfg`. 0xC5 takes one byte whose bits [1:0] go into `addr_bank`. With `wr_latch` at 0, these opcodes change nothing, and the bytes after them are decoded as opcodes.
- R8: Opcode 0xB7 sets `wide_addr` and opcode 0xE9 clears it, with no dependence on `wr_latch`.
- R9: While `sel` is low the block returns to waiting for an opcode (`await_op`=1), and a write that is still collecting data is dropped. `await_op` is 0 only while data bytes of a configuration write are expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Command window active (high) |
| byte_valid | input | 1 | A byte is present on `byte_in` this cycle |
| byte_in | input | 8 | Opcode or data byte |
| persist_cfg | output | 16 | Persistent configuration word |
| vol_cfg | output | 8 | Volatile configuration register |
| xvol_cfg | output | 8 | Enhanced volatile configuration register |
| wide_addr | output | 1 | 4-byte addressing selected |
| addr_bank | output | 2 | Address bank register |
| wr_latch | output | 1 | Write-enable latch |
| await_op | output | 1 | Next byte is decoded as an opcode |

## Verification
Some properties are checked on every cycle. At most one register write strobe fires at a time. A software reset always leaves the latch clear, the persistent word unchanged and the fixed bits of both volatile registers set. Deselection always returns the decoder to waiting for an opcode. A write opcode seen with the latch clear never enters data collection. The arming flag only rises after the arming opcode. The field-by-field derivation across the persistent word can only be shown by the bench scenarios: the bench writes 2048 persistent words, each followed by a software reset. The bench scenarios also cover the disarm-by-intervening-opcode case, a partial write dropped at deselect, and writes refused while the latch is clear.

// File: rtl/flashcfg_pkg.sv
// Shared constants and types for the flash configuration register block.
// Assumes byte-granular command traffic; field positions are fixed by the
// reset derivation and are therefore not parameters.
package flashcfg_pkg;
    localparam int NV_W     = 16;
    localparam int BYTE_W   = 8;
    localparam int BANK_W   = 2;
    localparam int DRIVE_W  = 3;

    localparam logic [BYTE_W-1:0] OP_LATCH_SET = 8'h06;
    localparam logic [BYTE_W-1:0] OP_LATCH_CLR = 8'h04;
    localparam logic [BYTE_W-1:0] OP_ARM       = 8'h66;
    localparam logic [BYTE_W-1:0] OP_FIRE      = 8'h99;
    localparam logic [BYTE_W-1:0] OP_WIDE_ON   = 8'hB7;
    localparam logic [BYTE_W-1:0] OP_WIDE_OFF  = 8'hE9;
    localparam logic [BYTE_W-1:0] OP_WR_NV     = 8'hB1;
    localparam logic [BYTE_W-1:0] OP_WR_VOL    = 8'h81;
    localparam logic [BYTE_W-1:0] OP_WR_XVOL   = 8'h61;
    localparam logic [BYTE_W-1:0] OP_WR_BANK   = 8'hC5;

    typedef struct packed {
        logic [BYTE_W-1:0] vol;
        logic [BYTE_W-1:0] xvol;
        logic              wide;
        logic [BANK_W-1:0] bank;
    } derived_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_NV,
        TGT_VOL,
        TGT_XVOL,
        TGT_BANK
    } tgt_e;

    typedef enum logic {
        ST_OP,
        ST_DATA
    } dec_state_e;
endpackage

// File: rtl/cfg_reload_calc.sv
// Computes the volatile state that a reset installs, from a persistent word.
// Purely combinational; assumes the caller registers the result.
module cfg_reload_calc
    import flashcfg_pkg::*;
#(
    parameter logic [DRIVE_W-1:0] DRIVE_STRENGTH = 3'd7
) (
    input  logic [NV_W-1:0] nv,
    output derived_t        derived
);
    localparam int DUMMY_LO = 12;
    localparam int XIP_LO   = 9;
    localparam int XIP_W    = 3;

    logic [XIP_W-1:0] xip_field;
    assign xip_field = nv[XIP_LO +: XIP_W];

    // Build the volatile register: fixed bits, execute-in-place, dummy count.
    always_comb begin
        derived.vol       = '0;
        derived.vol[0]    = 1'b1;
        derived.vol[1]    = 1'b1;
        derived.vol[3]    = (xip_field != {XIP_W{1'b1}});
        derived.vol[7:4]  = nv[DUMMY_LO +: 4];
    end

    // Build the enhanced volatile register: drive, fixed flags, I/O widths.
    always_comb begin
        derived.xvol                 = '0;
        derived.xvol[DRIVE_W-1:0]    = DRIVE_STRENGTH;
        derived.xvol[3]              = 1'b1;
        derived.xvol[4]              = 1'b1;
        derived.xvol[6]              = nv[2];
        derived.xvol[7]              = nv[3];
    end

    // Address mode and bank selection from the two low persistent bits.
    always_comb begin
        derived.wide = ~nv[0];
        derived.bank = nv[1] ? '0 : {BANK_W{1'b1}};
    end
endmodule

// File: rtl/cfg_cmd_decoder.sv
// Decodes opcode and data bytes into register strobes and the software
// reset pulse. Assumes one byte per valid cycle while sel is high; strobes
// are combinational and take effect at the same clock edge.
module cfg_cmd_decoder
    import flashcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              latch_q,
    output logic              latch_set,
    output logic              latch_clr,
    output logic              wide_set,
    output logic              wide_clr,
    output logic              wr_nv,
    output logic              wr_vol,
    output logic              wr_xvol,
    output logic              wr_bank,
    output logic [NV_W-1:0]   wr_data,
    output logic              sw_reset,
    output logic              await_op
);
    dec_state_e        state_q;
    tgt_e              tgt_q;
    logic [BYTE_W-1:0] lo_q;
    logic              have_lo_q;
    logic              armed_q;
    logic              fire;
    logic              is_wr_op;
    tgt_e              op_tgt;

    assign fire     = sel & byte_valid;
    assign await_op = (state_q == ST_OP);

    // Map a write opcode onto its target register.
    always_comb begin
        is_wr_op = 1'b1;
        unique case (byte_in)
            OP_WR_NV:   op_tgt = TGT_NV;
            OP_WR_VOL:  op_tgt = TGT_VOL;
            OP_WR_XVOL: op_tgt = TGT_XVOL;
            OP_WR_BANK: op_tgt = TGT_BANK;
            default: begin
                op_tgt   = TGT_NONE;
                is_wr_op = 1'b0;
            end
        endcase
    end

    // Produce the strobes for the byte presented this cycle.
    always_comb begin
        latch_set = 1'b0;
        latch_clr = 1'b0;
        wide_set  = 1'b0;
        wide_clr  = 1'b0;
        sw_reset  = 1'b0;
        wr_nv     = 1'b0;
        wr_vol    = 1'b0;
        wr_xvol   = 1'b0;
        wr_bank   = 1'b0;
        wr_data   = {{(NV_W-BYTE_W){1'b0}}, byte_in};
        if (fire && state_q == ST_OP) begin
            latch_set = (byte_in == OP_LATCH_SET);
            latch_clr = (byte_in == OP_LATCH_CLR);
            wide_set  = (byte_in == OP_WIDE_ON);
            wide_clr  = (byte_in == OP_WIDE_OFF);
            sw_reset  = (byte_in == OP_FIRE) && armed_q;
        end else if (fire && state_q == ST_DATA) begin
            unique case (tgt_q)
                TGT_NV: begin
                    wr_nv   = have_lo_q;
                    wr_data = {byte_in, lo_q};
                end
                TGT_VOL:  wr_vol  = 1'b1;
                TGT_XVOL: wr_xvol = 1'b1;
                TGT_BANK: wr_bank = 1'b1;
                default: ;
            endcase
        end
    end

    // Sequence opcode and data phases and track the reset arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OP;
            tgt_q     <= TGT_NONE;
            lo_q      <= '0;
            have_lo_q <= 1'b0;
            armed_q   <= 1'b0;
        end else if (!sel) begin
            state_q   <= ST_OP;
            tgt_q     <= TGT_NONE;
            have_lo_q <= 1'b0;
        end else if (fire) begin
            if (state_q == ST_OP) begin
                armed_q <= (byte_in == OP_ARM);
                if (is_wr_op && latch_q) begin
                    state_q <= ST_DATA;
                    tgt_q   <= op_tgt;
                end
            end else if (tgt_q == TGT_NV && !have_lo_q) begin
                lo_q      <= byte_in;
                have_lo_q <= 1'b1;
            end else begin
                state_q   <= ST_OP;
                tgt_q     <= TGT_NONE;
                have_lo_q <= 1'b0;
            end
        end
    end

    assert_one_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_nv, wr_vol, wr_xvol, wr_bank}));

    assert_no_data_without_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && state_q == ST_OP && is_wr_op && !latch_q) |=> (state_q == ST_OP));

    assert_deselect_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> await_op);

    assert_arm_after_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(fire && state_q == ST_OP && byte_in == OP_ARM));
endmodule

// File: rtl/cfg_reg_bank.sv
// Holds the persistent word, volatile registers, address state and the
// write-enable latch. Assumes strobes from the decoder are mutually
// consistent; a software reset takes priority over every other update.
module cfg_reg_bank
    import flashcfg_pkg::*;
#(
    parameter logic [NV_W-1:0] NV_DEFAULT = 16'h8FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  derived_t          boot_state,
    input  derived_t          live_state,
    input  logic              latch_set,
    input  logic              latch_clr,
    input  logic              wide_set,
    input  logic              wide_clr,
    input  logic              wr_nv,
    input  logic              wr_vol,
    input  logic              wr_xvol,
    input  logic              wr_bank,
    input  logic [NV_W-1:0]   wr_data,
    input  logic              sw_reset,
    output logic [NV_W-1:0]   nv_q,
    output logic [BYTE_W-1:0] vol_q,
    output logic [BYTE_W-1:0] xvol_q,
    output logic              wide_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              latch_q
);
    // Persistent word: parameter on hardware reset, kept on software reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     nv_q <= NV_DEFAULT;
        else if (wr_nv) nv_q <= wr_data;
    end

    // Volatile registers: reloaded on any reset, else written by command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_q  <= boot_state.vol;
            xvol_q <= boot_state.xvol;
        end else if (sw_reset) begin
            vol_q  <= live_state.vol;
            xvol_q <= live_state.xvol;
        end else begin
            if (wr_vol)  vol_q  <= wr_data[BYTE_W-1:0];
            if (wr_xvol) xvol_q <= wr_data[BYTE_W-1:0];
        end
    end

    // Addressing state: reloaded on any reset, else set by command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= boot_state.wide;
            bank_q <= boot_state.bank;
        end else if (sw_reset) begin
            wide_q <= live_state.wide;
            bank_q <= live_state.bank;
        end else begin
            if (wide_set)      wide_q <= 1'b1;
            else if (wide_clr) wide_q <= 1'b0;
            if (wr_bank)       bank_q <= wr_data[BANK_W-1:0];
        end
    end

    // Write-enable latch: cleared by any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) latch_q <= 1'b0;
        else if (latch_set)     latch_q <= 1'b1;
        else if (latch_clr)     latch_q <= 1'b0;
    end

    assert_reset_clears_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> !latch_q);

    assert_reset_keeps_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> $stable(nv_q));

    assert_reset_fixed_vol_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (vol_q[1:0] == 2'b11 && vol_q[2] == 1'b0));

    assert_reset_fixed_xvol_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (xvol_q[4:3] == 2'b11 && xvol_q[5] == 1'b0));

    assert_latch_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_set |=> latch_q);
endmodule

// File: rtl/flash_cfg_regs.sv
// Top level of the flash configuration register block: byte decoder,
// register bank and two reload calculators (boot value and live value).
// Assumes bytes are already deserialized and sel frames each command group.
module flash_cfg_regs
    import flashcfg_pkg::*;
#(
    parameter logic [NV_W-1:0]    NV_DEFAULT     = 16'h8FFF,
    parameter logic [DRIVE_W-1:0] DRIVE_STRENGTH = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [NV_W-1:0]   persist_cfg,
    output logic [BYTE_W-1:0] vol_cfg,
    output logic [BYTE_W-1:0] xvol_cfg,
    output logic              wide_addr,
    output logic [BANK_W-1:0] addr_bank,
    output logic              wr_latch,
    output logic              await_op
);
    derived_t        boot_state;
    derived_t        live_state;
    logic            latch_set, latch_clr, wide_set, wide_clr;
    logic            wr_nv, wr_vol, wr_xvol, wr_bank, sw_reset;
    logic [NV_W-1:0] wr_data;

    cfg_reload_calc #(.DRIVE_STRENGTH(DRIVE_STRENGTH)) u_boot_calc (
        .nv      (NV_DEFAULT),
        .derived (boot_state)
    );

    cfg_reload_calc #(.DRIVE_STRENGTH(DRIVE_STRENGTH)) u_live_calc (
        .nv      (persist_cfg),
        .derived (live_state)
    );

    cfg_cmd_decoder u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .latch_q    (wr_latch),
        .latch_set  (latch_set),
        .latch_clr  (latch_clr),
        .wide_set   (wide_set),
        .wide_clr   (wide_clr),
        .wr_nv      (wr_nv),
        .wr_vol     (wr_vol),
        .wr_xvol    (wr_xvol),
        .wr_bank    (wr_bank),
        .wr_data    (wr_data),
        .sw_reset   (sw_reset),
        .await_op   (await_op)
    );

    cfg_reg_bank #(.NV_DEFAULT(NV_DEFAULT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_state (boot_state),
        .live_state (live_state),
        .latch_set  (latch_set),
        .latch_clr  (latch_clr),
        .wide_set   (wide_set),
        .wide_clr   (wide_clr),
        .wr_nv      (wr_nv),
        .wr_vol     (wr_vol),
        .wr_xvol    (wr_xvol),
        .wr_bank    (wr_bank),
        .wr_data    (wr_data),
        .sw_reset   (sw_reset),
        .nv_q       (persist_cfg),
        .vol_q      (vol_cfg),
        .xvol_q     (xvol_cfg),
        .wide_q     (wide_addr),
        .bank_q     (addr_bank),
        .latch_q    (wr_latch)
    );
endmodule

// File: tb/test_flash_cfg_regs.sv
// Self-checking bench: directed scenarios plus a sweep of persistent words.
module test_flash_cfg_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [15:0] persist_cfg;
    logic [7:0]  vol_cfg, xvol_cfg;
    logic        wide_addr, wr_latch, await_op;
    logic [1:0]  addr_bank;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cfg_regs i_flash_cfg_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .byte_valid(byte_valid),
        .byte_in(byte_in), .persist_cfg(persist_cfg), .vol_cfg(vol_cfg),
        .xvol_cfg(xvol_cfg), .wide_addr(wide_addr), .addr_bank(addr_bank),
        .wr_latch(wr_latch), .await_op(await_op)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one byte for one cycle; returns after the capturing edge.
    task automatic put(input logic [7:0] b);
        @(negedge clk);
        sel = 1'b1; byte_valid = 1'b1; byte_in = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic drop_sel();
        @(negedge clk);
        sel = 1'b0; byte_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_vol(input logic [15:0] nv);
        return 8'h03 | ((nv[11:9] != 3'b111) ? 8'h08 : 8'h00) | {nv[15:12], 4'h0};
    endfunction
    function automatic logic [7:0] exp_xvol(input logic [15:0] nv);
        return 8'h1F | {nv[3], nv[2], 6'h00};
    endfunction

    task automatic chk_derived(input string tg, input logic [15:0] nv);
        chk({tg, " R2 vol"},  {8'h00, vol_cfg},  {8'h00, exp_vol(nv)});
        chk({tg, " R3 xvol"}, {8'h00, xvol_cfg}, {8'h00, exp_xvol(nv)});
        chk({tg, " R4 wide"}, {15'h0, wide_addr}, {15'h0, ~nv[0]});
        chk({tg, " R4 bank"}, {14'h0, addr_bank}, nv[1] ? 16'h0 : 16'h3);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 nv", persist_cfg, 16'h8FFF);
        chk("R1 vol", {8'h0, vol_cfg}, 16'h0083);
        chk("R1 xvol", {8'h0, xvol_cfg}, 16'h00DF);
        chk("R1 wide", {15'h0, wide_addr}, 16'h0);
        chk("R1 bank", {14'h0, addr_bank}, 16'h0);
        chk("R1 latch", {15'h0, wr_latch}, 16'h0);
        chk("R1 await", {15'h0, await_op}, 16'h1);

        // R6 latch set and clear
        put(8'h06);
        chk("R6 set", {15'h0, wr_latch}, 16'h1);
        put(8'h04);
        chk("R6 clr", {15'h0, wr_latch}, 16'h0);

        // R7 refused without latch: data bytes become opcodes
        put(8'hB1); put(8'h12); put(8'h34);
        chk("R7 locked nv", persist_cfg, 16'h8FFF);
        put(8'h81); put(8'h5A);
        chk("R7 locked vol", {8'h0, vol_cfg}, 16'h0083);

        // R7 writes with latch
        put(8'h06); put(8'h81);
        chk("R9 await data", {15'h0, await_op}, 16'h0);
        put(8'h5A);
        chk("R7 vol", {8'h0, vol_cfg}, 16'h005A);
        chk("R6 kept", {15'h0, wr_latch}, 16'h1);
        put(8'h61); put(8'hA5);
        chk("R7 xvol", {8'h0, xvol_cfg}, 16'h00A5);
        put(8'hC5); put(8'hFE);
        chk("R7 bank", {14'h0, addr_bank}, 16'h2);
        put(8'hB1); put(8'hCD); put(8'hAB);
        chk("R7 nv lo first", persist_cfg, 16'hABCD);

        // R8 wide address mode
        put(8'hB7);
        chk("R8 on", {15'h0, wide_addr}, 16'h1);
        put(8'hE9);
        chk("R8 off", {15'h0, wide_addr}, 16'h0);

        // R5 disarmed by intervening opcode: nothing reloads
        put(8'h66); put(8'h00); put(8'h99);
        chk("R5 disarm vol", {8'h0, vol_cfg}, 16'h005A);
        chk("R5 disarm latch", {15'h0, wr_latch}, 16'h1);
        put(8'h99);
        chk("R5 bare fire", {8'h0, xvol_cfg}, 16'h00A5);

        // R5 armed software reset reloads from 0xABCD
        put(8'h66); put(8'h99);
        chk("R5 latch", {15'h0, wr_latch}, 16'h0);
        chk("R5 nv kept", persist_cfg, 16'hABCD);
        chk("R5 await", {15'h0, await_op}, 16'h1);
        chk_derived("R5 reload", 16'hABCD);

        // R9 partial write dropped on deselect
        put(8'h06); put(8'hB1); put(8'h11);
        drop_sel();
        chk("R9 idle", {15'h0, await_op}, 16'h1);
        put(8'h22);
        chk("R9 nv", persist_cfg, 16'hABCD);
        put(8'h81); put(8'h3C);
        chk("R9 next frame", {8'h0, vol_cfg}, 16'h003C);
        drop_sel();

        // Sweep: R2 R3 R4 across dummy nibble, xip field, low nibble
        for (int d = 0; d < 16; d++) begin
            for (int x = 0; x < 8; x++) begin
                for (int l = 0; l < 16; l++) begin
                    logic [15:0] w;
                    w = {d[3:0], x[2:0], 5'(d * 3 + l), l[3:0]};
                    put(8'h06); put(8'hB1); put(w[7:0]); put(w[15:8]);
                    put(8'h66); put(8'h99);
                    chk("R7 sweep nv", persist_cfg, w);
                    chk_derived("sweep", w);
                end
            end
        end

        // R1 hardware reset restores default
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rerun nv", persist_cfg, 16'h8FFF);
        chk_derived("R1 rerun", 16'h8FFF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule